// File: doc/BRIEF.md
# Register-Controlled Serial Master Shifter

This block is a byte-wide serial master engine driven through a small register bus. Software loads a data byte, sets the frame length and the bit rate in a divider register, and then writes the mode register with its run bit set. The engine produces a serial clock from the system clock, shifts the data byte out most significant bit first, and shifts the input line into the least significant end of the same byte.

Software can poll the run bit, which clears on its own when the frame is done. It can also enable a completion interrupt. The block drives two pin-override outputs. One turns the serial clock pin into a push-pull output whenever the clock enable bit is set. The other turns the serial data output pin into a push-pull output under a separate control bit. The pins need no other preparation.

Top module: `spi_master_core`

## Requirements
- R1: The bus has four registers selected by `reg_addr`: 0 is the mode register, 1 the divider, 2 the pin control and 3 the data register. Only bit 0 of the pin control register is kept and its other bits read 0. After reset every register reads 0, and `sck`, `sout` and `irq` are low.
- R2: Mode bit layout: bit 6 is clock polarity, bit 5 is filter enable (stored only), bit 4 is clock enable, bit 3 is phase, bit 2 is start enable, bit 1 is input enable and bit 0 is interrupt enable. Bits 6 to 0 read back as written. Writing 3Eh reads back 3Eh.
- R3: A mode write with bits 7, 4 and 2 all set starts a frame, and bit 7 then reads 1 until the frame ends. A mode write with bit 7 set and bit 4 or bit 2 clear starts nothing, and bit 7 reads 0.
- R4: Divider bits 3:0 hold the frame length minus one (1 to 16 bits). Bits 7:4 hold a rate field R, and the serial clock half-period is max(R-3,1) system clocks. A frame of N bits with half-period H keeps bit 7 set for exactly 2·N·H cycles after the starting write. With 48h, H is 1 and N is 9.
- R5: While no frame runs, `sck` equals the polarity bit. A frame toggles `sck` 2·N times, once every H cycles.
- R6: Each sampling edge shifts the data register left and puts the sampled input in bit 0. The input is `sin`, or 0 when input enable is clear. After the frame the data register holds the result.
- R7: With phase 0, `sout` takes data bit 7 at the starting write and updates on every second edge. With phase 1, `sout` updates on the first edge of each bit, and sampling happens on the second edge.
- R8: `sck_oe` follows the clock enable bit and `sout_oe` follows pin control bit 0.
- R9: If interrupt enable is set, `irq` rises in the cycle the run bit clears. It stays high until the next accepted mode write.
- R10: While a frame runs, writes to the mode, divider and data registers are ignored. Writes to pin control are always accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| sin | input | 1 | Serial data input |
| sck | output | 1 | Serial clock |
| sout | output | 1 | Serial data output |
| sck_oe | output | 1 | Serial clock pin push-pull override |
| sout_oe | output | 1 | Serial data pin push-pull override |
| irq | output | 1 | Completion interrupt request |

## Verification
The end of a frame can fall in the same cycle as a register write. In that cycle the run bit clears and the interrupt is raised, so a mode write landing on that exact edge must still count as a write during the run and be ignored, and the interrupt must not be cleared. The bench counts 2·N·H cycles from the starting write and drives a mode write that is sampled on the final edge. It then expects the interrupt high, the old mode value and the run bit low, and a reference model checks every cycle around that edge.

// File: rtl/spi_master_core.sv
module spi_master_core #(
  parameter int LEN_W  = 4,
  parameter int RATE_W = 4,
  parameter int RATE_OFS = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       sin,
  output logic       sck,
  output logic       sout,
  output logic       sck_oe,
  output logic       sout_oe,
  output logic       irq
);
  localparam int EDGE_W = LEN_W + 1;

  logic [6:0]        mode_q;
  logic [7:0]        div_q, dat_q;
  logic              busy_q, pin_q, tog_q, sout_q, irq_q;
  logic [RATE_W-1:0] hcnt_q;
  logic [EDGE_W-1:0] edge_q;

  logic [RATE_W-1:0] rate, half_len;
  logic [EDGE_W-1:0] last_edge;
  logic tick, smp, done, idle_wr, go;

  assign rate      = div_q[7:8-RATE_W];
  assign half_len  = (rate > RATE_W'(RATE_OFS)) ? rate - RATE_W'(RATE_OFS) : RATE_W'(1);
  assign last_edge = {div_q[LEN_W-1:0], 1'b1};
  assign tick      = busy_q && (hcnt_q == half_len - RATE_W'(1));
  assign smp       = (edge_q[0] == mode_q[3]);
  assign done      = tick && (edge_q == last_edge);
  assign idle_wr   = reg_wr && !busy_q;
  assign go        = idle_wr && (reg_addr == 2'd0) && reg_wdata[7] && reg_wdata[4] && reg_wdata[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      div_q  <= '0;
      dat_q  <= '0;
      pin_q  <= 1'b0;
      busy_q <= 1'b0;
      tog_q  <= 1'b0;
      sout_q <= 1'b0;
      irq_q  <= 1'b0;
      hcnt_q <= '0;
      edge_q <= '0;
    end else begin
      if (reg_wr && reg_addr == 2'd2) pin_q <= reg_wdata[0];
      if (idle_wr) begin
        case (reg_addr)
          2'd0:    mode_q <= reg_wdata[6:0];
          2'd1:    div_q  <= reg_wdata;
          2'd3:    dat_q  <= reg_wdata;
          default: ;
        endcase
      end
      if (done && mode_q[0])                 irq_q <= 1'b1;
      else if (idle_wr && reg_addr == 2'd0)  irq_q <= 1'b0;
      if (go)        busy_q <= 1'b1;
      else if (done) busy_q <= 1'b0;
      if (go || tick)  hcnt_q <= '0;
      else if (busy_q) hcnt_q <= hcnt_q + RATE_W'(1);
      if (go)        edge_q <= '0;
      else if (tick) edge_q <= edge_q + EDGE_W'(1);
      if (go)        tog_q <= 1'b0;
      else if (tick) tog_q <= ~tog_q;
      if (tick && smp) dat_q <= {dat_q[6:0], mode_q[1] & sin};
      if (go && !reg_wdata[3])  sout_q <= dat_q[7];
      else if (tick && !smp)    sout_q <= dat_q[7];
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = {busy_q, mode_q};
      2'd1:    reg_rdata = div_q;
      2'd2:    reg_rdata = {7'd0, pin_q};
      default: reg_rdata = dat_q;
    endcase
  end

  assign sck     = tog_q ^ mode_q[6];
  assign sout    = sout_q;
  assign sck_oe  = mode_q[4];
  assign sout_oe = pin_q;
  assign irq     = irq_q;
endmodule

module spi_master_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       cpol,
  input logic       sck,
  input logic       sck_oe,
  input logic       irq,
  input logic       reg_wr,
  input logic [1:0] reg_addr
);
  assert_sck_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (sck == cpol));
  assert_start_by_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr && reg_addr == 2'd0));
  assert_irq_on_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $fell(busy));
  assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(reg_wr && reg_addr == 2'd0)) |=> irq);
  assert_oe_in_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> sck_oe);
endmodule

bind spi_master_core spi_master_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_q), .cpol(mode_q[6]), .sck(sck),
  .sck_oe(sck_oe), .irq(irq), .reg_wr(reg_wr), .reg_addr(reg_addr)
);

// File: tb/sim_spi_master_core.sv
module sim_spi_master_core;
  logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, sin = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0, reg_rdata;
  logic sck, sout, sck_oe, sout_oe, irq;
  int checks = 0, fails = 0;
  int sin_force = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  spi_master_core u0 (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sin(sin), .sck(sck), .sout(sout),
    .sck_oe(sck_oe), .sout_oe(sout_oe), .irq(irq));

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    sin  <= (sin_force == 1) ? 1'b1 : lfsr[0];
  end

  int m_mode, m_div, m_data, m_pin, m_busy, m_tog, m_sout, m_irq, m_h, m_e;
  always @(posedge clk) begin
    int ob, hl, nb;
    if (!rst_n) begin
      m_mode = 0; m_div = 0; m_data = 0; m_pin = 0; m_busy = 0;
      m_tog = 0; m_sout = 0; m_irq = 0; m_h = 0; m_e = 0;
    end else begin
      ob = m_busy;
      hl = ((m_div >> 4) > 3) ? (m_div >> 4) - 3 : 1;
      nb = (m_div & 15) + 1;
      if (ob != 0) begin
        if (m_h == hl - 1) begin
          m_h = 0;
          m_tog = m_tog ^ 1;
          if ((m_e % 2) == ((m_mode >> 3) & 1))
            m_data = ((m_data << 1) | ((((m_mode >> 1) & 1) != 0) ? int'(sin) : 0)) & 255;
          else
            m_sout = (m_data >> 7) & 1;
          if (m_e == 2 * nb - 1) begin
            m_busy = 0;
            if ((m_mode & 1) != 0) m_irq = 1;
          end
          m_e++;
        end else m_h++;
      end
      if (reg_wr) begin
        if (reg_addr == 2'd2) m_pin = int'(reg_wdata[0]);
        if (ob == 0) begin
          case (reg_addr)
            2'd0: begin
              m_mode = int'(reg_wdata) & 127;
              m_irq = 0;
              if (reg_wdata[7] && reg_wdata[4] && reg_wdata[2]) begin
                m_busy = 1; m_h = 0; m_e = 0; m_tog = 0;
                if (!reg_wdata[3]) m_sout = (m_data >> 7) & 1;
              end
            end
            2'd1: m_div = int'(reg_wdata);
            2'd3: m_data = int'(reg_wdata);
            default: ;
          endcase
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int er;
    #5;
    if (rst_n) begin
      case (reg_addr)
        2'd0: er = (m_busy << 7) | m_mode;
        2'd1: er = m_div;
        2'd2: er = m_pin;
        default: er = m_data;
      endcase
      chk(int'(sck) == (m_tog ^ ((m_mode >> 6) & 1)), "R5 sck", int'(sck), m_tog ^ ((m_mode >> 6) & 1));
      chk(int'(sout) == m_sout, "R7 sout", int'(sout), m_sout);
      chk(int'(sck_oe) == ((m_mode >> 4) & 1), "R8 sck_oe", int'(sck_oe), (m_mode >> 4) & 1);
      chk(int'(sout_oe) == m_pin, "R8 sout_oe", int'(sout_oe), m_pin);
      chk(int'(irq) == m_irq, "R9 irq", int'(irq), m_irq);
      chk(int'(reg_rdata) == er, "R1 rdata", int'(reg_rdata), er);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic run_len(output int n);
    logic [7:0] v;
    n = 0;
    rd(2'd0, v);
    while (v[7]) begin
      @(negedge clk);
      n++;
      rd(2'd0, v);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R3 watchdog actual=hung expected=idle");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk(v == 8'h00, "R1 reset", int'(v), 0);
    end
    chk(sck == 1'b0 && sout == 1'b0 && irq == 1'b0, "R1 reset pins", int'({sck, sout, irq}), 0);

    wr(2'd0, 8'h3E);
    rd(2'd0, v);
    chk(v == 8'h3E, "R2 readback", int'(v), 8'h3E);
    chk(sck_oe == 1'b1, "R8 clock override", int'(sck_oe), 1);
    wr(2'd2, 8'hFF);
    rd(2'd2, v);
    chk(v == 8'h01 && sout_oe, "R8 pin control", int'(v), 1);

    wr(2'd1, 8'h48);
    wr(2'd3, 8'hAA);
    wr(2'd0, 8'hBE);
    run_len(n);
    chk(n == 18, "R4 frame cycles 48h", n, 18);

    wr(2'd0, 8'h9A);
    rd(2'd0, v);
    chk(v == 8'h1A, "R3 no start without start enable", int'(v), 8'h1A);
    wr(2'd0, 8'hA6);
    rd(2'd0, v);
    chk(v == 8'h26 && sck_oe == 1'b0, "R3 no start without clock enable", int'(v), 8'h26);

    sin_force = 1;
    wr(2'd1, 8'h67);
    wr(2'd3, 8'h5A);
    wr(2'd0, 8'hD7);
    wr(2'd1, 8'h00);
    wr(2'd3, 8'h11);
    run_len(n);
    chk(n == 44, "R4 frame cycles 67h", n, 44);
    rd(2'd3, v);
    chk(v == 8'hFF, "R6 all ones in", int'(v), 8'hFF);
    rd(2'd1, v);
    chk(v == 8'h67, "R10 divider kept", int'(v), 8'h67);
    chk(irq == 1'b1 && sck == 1'b1, "R9 irq raised", int'(irq), 1);
    repeat (3) @(negedge clk);
    chk(irq == 1'b1, "R9 irq held", int'(irq), 1);

    wr(2'd3, 8'hC3);
    wr(2'd0, 8'h95);
    chk(irq == 1'b0, "R9 irq cleared", int'(irq), 0);
    run_len(n);
    rd(2'd3, v);
    chk(v == 8'h00, "R6 input disabled", int'(v), 0);
    sin_force = 0;

    wr(2'd1, 8'h47);
    wr(2'd3, 8'h96);
    wr(2'd0, 8'h9E);
    run_len(n);
    chk(n == 16, "R7 phase 1 frame", n, 16);

    wr(2'd1, 8'h67);
    wr(2'd3, 8'h3C);
    wr(2'd0, 8'h95);
    repeat (47) @(negedge clk);
    reg_addr = 2'd0; reg_wdata = 8'h00; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    rd(2'd0, v);
    chk(v == 8'h15, "R10 write on final edge ignored", int'(v), 8'h15);
    chk(irq == 1'b1, "R9 irq on final edge", int'(irq), 1);

    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule